// File: doc/BRIEF.md
# Addressed Two-Wire Control Receiver

This block is a write-only control slave that listens on a burst serial clock and one data line. Every transfer is a frame of eleven meaningful bits, sampled on rising clock edges and sent least significant payload bit first. The first bit is a start marker, the second is a read/write flag and the third says whether the frame is a command or data. The eight payload bits come last. The frame occupies fourteen clocks in total. After the last payload bit, the frame's result is presented as a one-interval strobe, and a register in the same clock domain captures it on the following rising edge.

Command frames carry a four-bit device code and a four-bit instruction. A command that names this device selects it. A command that names any other device deselects it. Instructions choose how the internal address pointer moves after each register write: up by one, down by one, or held. Other instructions arm the next data frame to load the pointer, or request a clear of the control registers. When the device is selected, each data frame either loads the pointer or writes its payload to the pointed register. Register writes are confined to a small legal address window.

Top module: `ctl_serial_rx`

## Requirements
- R1: Framing. While idle, a 0 on the data line at a rising edge is ignored. A 1 starts a frame. The next ten rising edges sample, in order: read/write (1 = write), data/command (1 = command, 0 = data), then payload bits 0 through 7.
- R2: After reset the receiver is deselected. Data frames cause no write until a command frame carrying device code 5 (payload bits 3:0) arrives. Any instruction selects the device, including the no-op.
- R3: A command frame whose payload bits 3:0 differ from 5 deselects the device, and it carries out none of its instruction. Data frames then cause no write until a command with code 5 arrives again.
- R4: Instruction 4'b0010 (payload bits 7:4) arms the next data frame to load its payload into the address pointer without writing a register. Any other command frame cancels the arming.
- R5: A data frame received while selected and not armed presents `wr_en` with `wr_addr` equal to the pointer and `wr_data` equal to the payload. The strobe lasts exactly the interval between the 11th and 12th rising edges, counting the start bit as the 1st edge.
- R6: A data frame aimed at a pointer value above MAX_ADDR (default 4) raises no `wr_en`, but it still moves the pointer according to the address mode.
- R7: Instruction 4'b0011 selects increment mode and 4'b0100 selects decrement mode. Instruction 4'b0101 selects hold mode. After each non-loading data frame the pointer steps accordingly, with modulo-256 wrap. The mode persists until another mode instruction.
- R8: Instruction 4'b0001 with code 5 raises `reg_clear` for the same interval as R5. It does not change the pointer, the address mode or the selection.
- R9: A frame whose read/write bit is 0 has no effect at all.
- R10: A frame spans 14 rising edges from the start bit. The line value on the 12th to 14th edges is ignored, and a start bit may be sampled on the very next edge.
- R11: Instruction codes 4'b0110 through 4'b1111, and 4'b0000, leave the address mode and the pointer unchanged.
- R12: Reset leaves the pointer at 0 in hold mode, with `wr_en` and `reg_clear` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Burst serial clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_dat | input | 1 | Serial data line |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 8 | Register address for the write |
| wr_data | output | 8 | Register data for the write |
| reg_clear | output | 1 | Control-register clear strobe |

## Verification
Every frame result is due in one interval only: the stretch after the rising edge that samples payload bit 7, which is the 11th edge counted from the start bit. The strobe is gone after the 12th edge, and the pointer has moved by then. The bench drives the line on falling edges and samples the strobes and their address and data on the falling edge just before the 12th rising edge. It also counts `wr_en` pulses on every rising edge, so a frame that should not write is shown at the ports to have written nothing. Pointer movement is observed through the address of the next write.

// File: rtl/ctl_rx_pkg.sv
package ctl_rx_pkg;
  localparam int PAY_W  = 8;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_INC  = 2'd1,
    MODE_DEC  = 2'd2
  } addr_mode_e;

  localparam logic [CODE_W-1:0] INS_NOP   = 4'd0;
  localparam logic [CODE_W-1:0] INS_CLEAR = 4'd1;
  localparam logic [CODE_W-1:0] INS_ALOAD = 4'd2;
  localparam logic [CODE_W-1:0] INS_INC   = 4'd3;
  localparam logic [CODE_W-1:0] INS_DEC   = 4'd4;
  localparam logic [CODE_W-1:0] INS_HOLD  = 4'd5;
endpackage

// File: rtl/ctl_rx_framer.sv
module ctl_rx_framer #(
  parameter int FRAME_CLKS = 14,
  parameter int BODY_BITS  = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sdi,
  output logic                 commit,
  output logic [BODY_BITS-1:0] body
);
  localparam int CNT_W = $clog2(FRAME_CLKS);
  localparam logic [CNT_W-1:0] LAST_IDX   = CNT_W'(FRAME_CLKS - 1);
  localparam logic [CNT_W-1:0] BODY_LAST  = CNT_W'(BODY_BITS);
  localparam logic [CNT_W-1:0] COMMIT_IDX = CNT_W'(BODY_BITS + 1);

  logic                 busy_q, busy_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [BODY_BITS-1:0] body_q, body_d;
  logic                 shift_en;

  always_comb begin
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    shift_en = busy_q && (cnt_q <= BODY_LAST);
    if (!busy_q) begin
      if (sdi) begin
        busy_d = 1'b1;
        cnt_d  = CNT_W'(1);
      end
    end else if (cnt_q == LAST_IDX) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    body_d = shift_en ? {sdi, body_q[BODY_BITS-1:1]} : body_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      body_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      body_q <= body_d;
    end
  end

  assign commit = busy_q && (cnt_q == COMMIT_IDX);
  assign body   = body_q;
endmodule

// File: rtl/ctl_rx_decoder.sv
module ctl_rx_decoder
  import ctl_rx_pkg::*;
#(
  parameter int DEV_CODE = 5,
  parameter int MAX_ADDR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [PAY_W+1:0] body,
  input  logic [PAY_W-1:0] cur_addr,
  output logic             wr_en,
  output logic             reg_clear,
  output logic             ld_addr,
  output logic             step_en,
  output logic             mode_set,
  output addr_mode_e       mode_val
);
  localparam logic [CODE_W-1:0] OWN_CODE = CODE_W'(DEV_CODE);
  localparam logic [PAY_W-1:0]  ADDR_TOP = PAY_W'(MAX_ADDR);

  logic              sel_q, sel_d;
  logic              arm_q, arm_d;
  logic              is_wr, is_cmd;
  logic              cmd_ok, dat_ok, own;
  logic [CODE_W-1:0] dev, ins;

  assign is_wr  = body[0];
  assign is_cmd = body[1];
  assign dev    = body[2 +: CODE_W];
  assign ins    = body[2+CODE_W +: CODE_W];
  assign own    = (dev == OWN_CODE);
  assign cmd_ok = commit && is_wr && is_cmd;
  assign dat_ok = commit && is_wr && !is_cmd;

  always_comb begin
    sel_d    = sel_q;
    arm_d    = arm_q;
    mode_set = 1'b0;
    mode_val = MODE_HOLD;
    if (cmd_ok) begin
      sel_d = own;
      arm_d = own && (ins == INS_ALOAD);
      if (own) begin
        case (ins)
          INS_INC:  begin mode_set = 1'b1; mode_val = MODE_INC;  end
          INS_DEC:  begin mode_set = 1'b1; mode_val = MODE_DEC;  end
          INS_HOLD: begin mode_set = 1'b1; mode_val = MODE_HOLD; end
          default:  ;
        endcase
      end
    end
    if (dat_ok && sel_q && arm_q) arm_d = 1'b0;
  end

  assign ld_addr   = dat_ok && sel_q && arm_q;
  assign step_en   = dat_ok && sel_q && !arm_q;
  assign wr_en     = step_en && (cur_addr <= ADDR_TOP);
  assign reg_clear = cmd_ok && own && (ins == INS_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      arm_q <= arm_d;
    end
  end
endmodule

// File: rtl/ctl_rx_pointer.sv
module ctl_rx_pointer
  import ctl_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_addr,
  input  logic [PAY_W-1:0] ld_val,
  input  logic             step_en,
  input  logic             mode_set,
  input  addr_mode_e       mode_val,
  output logic [PAY_W-1:0] addr
);
  logic [PAY_W-1:0] addr_q, addr_d;
  addr_mode_e       mode_q, mode_d;

  always_comb begin
    addr_d = addr_q;
    mode_d = mode_set ? mode_val : mode_q;
    if (ld_addr) begin
      addr_d = ld_val;
    end else if (step_en) begin
      case (mode_q)
        MODE_INC: addr_d = addr_q + PAY_W'(1);
        MODE_DEC: addr_d = addr_q - PAY_W'(1);
        default:  addr_d = addr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= MODE_HOLD;
    end else begin
      addr_q <= addr_d;
      mode_q <= mode_d;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/ctl_serial_rx.sv
module ctl_serial_rx
  import ctl_rx_pkg::*;
#(
  parameter int DEV_CODE   = 5,
  parameter int MAX_ADDR   = 4,
  parameter int FRAME_CLKS = 14
) (
  input  logic             ser_clk,
  input  logic             rst_n,
  input  logic             ser_dat,
  output logic             wr_en,
  output logic [PAY_W-1:0] wr_addr,
  output logic [PAY_W-1:0] wr_data,
  output logic             reg_clear
);
  localparam int BODY_BITS = PAY_W + 2;

  logic                 commit;
  logic [BODY_BITS-1:0] body;
  logic [PAY_W-1:0]     cur_addr;
  logic                 ld_addr, step_en, mode_set;
  addr_mode_e           mode_val;

  ctl_rx_framer #(.FRAME_CLKS(FRAME_CLKS), .BODY_BITS(BODY_BITS)) u_framer (
    .clk(ser_clk), .rst_n(rst_n), .sdi(ser_dat), .commit(commit), .body(body)
  );

  ctl_rx_decoder #(.DEV_CODE(DEV_CODE), .MAX_ADDR(MAX_ADDR)) u_decoder (
    .clk(ser_clk), .rst_n(rst_n), .commit(commit), .body(body),
    .cur_addr(cur_addr), .wr_en(wr_en), .reg_clear(reg_clear),
    .ld_addr(ld_addr), .step_en(step_en), .mode_set(mode_set), .mode_val(mode_val)
  );

  ctl_rx_pointer u_pointer (
    .clk(ser_clk), .rst_n(rst_n), .ld_addr(ld_addr), .ld_val(body[BODY_BITS-1:2]),
    .step_en(step_en), .mode_set(mode_set), .mode_val(mode_val), .addr(cur_addr)
  );

  assign wr_addr = cur_addr;
  assign wr_data = body[BODY_BITS-1:2];
endmodule

// File: rtl/ctl_serial_rx_chk.sv
module ctl_serial_rx_chk #(
  parameter int MAX_ADDR = 4
) (
  input logic       ser_clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic       reg_clear
);
  // R6
  wr_range_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
    wr_en |-> (wr_addr <= 8'(MAX_ADDR)));
  // R5
  wr_single_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R8
  clr_single_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
    reg_clear |=> !reg_clear);
  // R8
  strobe_excl_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
    !(wr_en && reg_clear));
  // R10
  wr_gap_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
    wr_en |=> !reg_clear);
endmodule

bind ctl_serial_rx ctl_serial_rx_chk #(.MAX_ADDR(MAX_ADDR)) u_chk (
  .ser_clk(ser_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .reg_clear(reg_clear)
);

// File: tb/ctl_serial_rx_bench.sv
module ctl_serial_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sdi;
  logic       wr_en, reg_clear;
  logic [7:0] wr_addr, wr_data;

  int tests = 0, fails = 0, wr_cnt = 0, cyc = 0;
  bit m_en = 0, m_pend = 0;
  logic [7:0] m_addr = 8'd0;
  int m_mode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_serial_rx u_ctl_serial_rx (
    .ser_clk(clk), .rst_n(rst_n), .ser_dat(sdi), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .reg_clear(reg_clear)
  );

  always @(posedge clk) begin
    if (rst_n === 1'b1 && wr_en === 1'b1) wr_cnt++;
    cyc++;
    if (cyc > WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog: act cycles=%0d exp below %0d", cyc, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic frame(input bit rw, input bit dc, input logic [7:0] pay,
                       input bit junk, input int gap, input string tag);
    logic [13:0] b;
    bit exp_wr, exp_clr, own;
    logic [7:0] exp_a;
    logic c_wr, c_clr;
    logic [7:0] c_a, c_d;
    int n0;
    own     = (pay[3:0] == 4'd5);
    exp_clr = rw && dc && own && (pay[7:4] == 4'd1);
    exp_wr  = rw && !dc && m_en && !m_pend && (m_addr <= 8'd4);
    exp_a   = m_addr;
    b = {junk, junk, junk, pay, dc, rw, 1'b1};
    n0 = wr_cnt;
    c_wr = 0; c_clr = 0; c_a = 0; c_d = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (i == 11) begin
        c_wr = wr_en; c_clr = reg_clear; c_a = wr_addr; c_d = wr_data;
      end
      sdi = b[i];
    end
    if (gap > 0) begin
      @(negedge clk);
      sdi = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
    chk(c_wr === exp_wr, {tag, " wr_en"}, int'(c_wr), int'(exp_wr));
    chk(c_clr === exp_clr, {tag, " reg_clear"}, int'(c_clr), int'(exp_clr));
    chk((wr_cnt - n0) == int'(exp_wr), {tag, " write count"}, wr_cnt - n0, int'(exp_wr));
    if (exp_wr) begin
      chk(c_a === exp_a, {tag, " wr_addr"}, int'(c_a), int'(exp_a));
      chk(c_d === pay, {tag, " wr_data"}, int'(c_d), int'(pay));
    end
    if (rw && dc) begin
      m_en   = own;
      m_pend = own && (pay[7:4] == 4'd2);
      if (own && pay[7:4] == 4'd3) m_mode = 1;
      if (own && pay[7:4] == 4'd4) m_mode = 2;
      if (own && pay[7:4] == 4'd5) m_mode = 0;
    end else if (rw && m_en) begin
      if (m_pend) begin
        m_addr = pay; m_pend = 0;
      end else if (m_mode == 1) m_addr = m_addr + 8'd1;
      else if (m_mode == 2) m_addr = m_addr - 8'd1;
    end
  endtask

  task automatic cmd(input logic [3:0] dev, input logic [3:0] ins, input string tag);
    frame(1'b1, 1'b1, {ins, dev}, 1'b0, 2, tag);
  endtask

  task automatic dat(input logic [7:0] v, input string tag);
    frame(1'b1, 1'b0, v, 1'b0, 2, tag);
  endtask

  initial begin
    rst_n = 1'b0;
    sdi = 1'b0;
    repeat (3) @(negedge clk);
    chk(wr_en === 1'b0, "R12 reset wr_en", int'(wr_en), 0);
    chk(reg_clear === 1'b0, "R12 reset reg_clear", int'(reg_clear), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    dat(8'hA5, "R2 deselected after reset");
    cmd(4'd5, 4'd0, "R2 own nop selects");
    dat(8'h3C, "R12 pointer zero hold");
    dat(8'hC3, "R12 hold keeps pointer");

    for (int a = 0; a < 8; a++) begin
      cmd(4'd5, 4'd2, "R4 arm load");
      dat(8'(a), "R4 load pointer");
      dat(8'(8'h50 + a), "R6 window write");
    end

    cmd(4'd5, 4'd2, "R4 arm load");
    cmd(4'd5, 4'd0, "R4 command cancels arm");
    dat(8'h11, "R4 cancelled arm writes");

    cmd(4'd5, 4'd2, "R4 arm"); dat(8'h00, "R4 load 0");
    cmd(4'd5, 4'd3, "R7 increment mode");
    for (int k = 0; k < 7; k++) dat(8'(8'h20 + k), "R7 increment sweep");

    cmd(4'd5, 4'd2, "R4 arm"); dat(8'h04, "R4 load 4");
    cmd(4'd5, 4'd4, "R7 decrement mode");
    for (int k = 0; k < 7; k++) dat(8'(8'h40 + k), "R7 decrement wrap sweep");

    cmd(4'd5, 4'd2, "R4 arm"); dat(8'h02, "R4 load 2");
    cmd(4'd5, 4'd5, "R7 hold mode");
    dat(8'h61, "R7 hold write");
    dat(8'h62, "R7 hold repeat");

    cmd(4'd5, 4'd3, "R7 increment mode");
    cmd(4'd5, 4'd1, "R8 clear strobe");
    dat(8'h71, "R8 pointer kept after clear");
    for (int u = 6; u < 16; u++) cmd(4'd5, 4'(u), "R11 unknown instruction");
    dat(8'h72, "R11 mode kept");

    cmd(4'd3, 4'd1, "R3 foreign clear ignored");
    dat(8'h81, "R3 deselected");
    cmd(4'd5, 4'd0, "R3 reselect");
    dat(8'h82, "R3 reselected write");

    frame(1'b0, 1'b0, 8'h91, 1'b0, 2, "R9 read data frame");
    frame(1'b0, 1'b1, 8'h15, 1'b0, 2, "R9 read command frame");
    dat(8'h92, "R9 state unchanged");

    cmd(4'd5, 4'd2, "R4 arm"); dat(8'h01, "R4 load 1");
    frame(1'b1, 1'b0, 8'hB1, 1'b1, 0, "R10 trailing ones");
    frame(1'b1, 1'b0, 8'hB2, 1'b1, 0, "R10 back to back");
    frame(1'b1, 1'b0, 8'hB3, 1'b0, 9, "R1 idle zeros ignored");
    dat(8'hB4, "R1 framing after idle");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule